// File: doc/BRIEF.md
# TDM Frame-Sync Pulse Generator

This block produces the frame clock of a serial audio port. It counts bit-clock cycles across each frame and raises its frame-sync output at the first bit clock of every frame. The output stays high either for half of the frame or, in TDM mode, for a programmed number of bit clocks. A one-cycle frame-start strobe marks the first bit clock of each frame.

The programmed high time is an 11-bit field. Its upper eight bits come from one byte-wide register and its lower three bits from another. A field value N keeps frame-sync high for N+1 bit clocks. The frame length is an input given in bit clocks. All settings are taken at frame boundaries only, so a pulse that has already started is never shortened or stretched.

Top module: `fsync_gen`

## Requirements
- R1: While `rst` is high, `fsync` and `frame_start` are low. The first frame starts on the cycle after the first rising edge at which `rst` is low.
- R2: Each frame lasts the effective frame length in bit clocks. `frame_start` is high only on the first cycle of a frame, and `fsync` rises on that same cycle.
- R3: With `tdm_en`=1 and `half_duty`=0, `fsync` stays high for N+1 cycles. N is `{hi_upper, hi_lower}`, with `hi_upper` as bits [10:3] and `hi_lower` as bits [2:0].
- R4: With `half_duty`=1, or with `tdm_en`=0 whatever `half_duty` is, `fsync` stays high for floor(L/2) cycles, where L is the effective frame length.
- R5: When the requested high time is L or more, `fsync` stays high for L-1 cycles, so the last cycle of every frame is low.
- R6: A `frame_len` value below 2 is treated as an effective length of 2.
- R7: The settings are sampled at the rising edge that starts a frame. Changes made during a frame take effect only from the next frame onward.
- R8: The largest field value, 2047, gives a high time of 2048 cycles when the frame is longer than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| tdm_en | input | 1 | TDM mode enable |
| half_duty | input | 1 | 1 selects half-frame high time, 0 selects the programmed width |
| hi_upper | input | 8 | High-time field bits [10:3] |
| hi_lower | input | 3 | High-time field bits [2:0] |
| frame_len | input | 12 | Frame length in bit clocks |
| fsync | output | 1 | Frame-sync output |
| frame_start | output | 1 | One-cycle strobe on the first bit clock of a frame |

## Verification
The bench changes the settings at the start of a frame, while that frame is still running. A design that applied new settings at once would cut the pulse short or stretch it in the current frame.

It drives the programmed field at 0, 1 and 2047, and asks for high times longer than the frame. A design that forgot the +1 would drop one high cycle. A design without the clamp would hold frame-sync high across the frame boundary with no low cycle.

Odd frame lengths and lengths of 0 and 1 check the rounding and the minimum length. Getting these wrong would show as a strobe stuck high or as a high time one cycle off. Non-TDM frames with `half_duty`=0 catch a design that lets the programmed width leak into the plain mode.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

  // Shortest frame that still leaves one low cycle after a one-cycle pulse.
  localparam int unsigned MIN_FRAME = 2;

  typedef enum logic {WIDTH_HALF = 1'b0, WIDTH_PROG = 1'b1} width_mode_e;

  // The programmed width is used only in TDM mode with the half-duty select clear.
  function automatic width_mode_e pick_mode(input logic tdm, input logic half);
    return (tdm && !half) ? WIDTH_PROG : WIDTH_HALF;
  endfunction

  function automatic int unsigned clamp_len(input int unsigned len);
    return (len < MIN_FRAME) ? MIN_FRAME : len;
  endfunction

  // High cycles in one frame, limited so that the frame ends low.
  function automatic int unsigned high_cycles(input width_mode_e mode,
                                              input int unsigned field,
                                              input int unsigned len);
    int unsigned want;
    want = (mode == WIDTH_PROG) ? field + 1 : len / 2;
    if (want > len - 1) want = len - 1;
    return want;
  endfunction

endpackage

// File: rtl/fsync_cfg.sv
module fsync_cfg #(
  parameter int HI_W  = 11,
  parameter int LO_W  = 3,
  parameter int LEN_W = 12,
  parameter int CNT_W = 12
) (
  input  logic              tdm_en,
  input  logic              half_duty,
  input  logic [HI_W-LO_W-1:0] hi_upper,
  input  logic [LO_W-1:0]   hi_lower,
  input  logic [LEN_W-1:0]  frame_len,
  output logic [CNT_W-1:0]  len_eff,
  output logic [CNT_W-1:0]  hi_eff
);
  import fsync_pkg::*;

  logic [HI_W-1:0] field;
  width_mode_e     mode;
  int unsigned     len_i;
  int unsigned     hi_i;

  assign field = {hi_upper, hi_lower};
  assign mode  = pick_mode(tdm_en, half_duty);

  always_comb begin
    len_i = clamp_len(32'(frame_len));
    hi_i  = high_cycles(mode, 32'(field), len_i);
  end

  assign len_eff = CNT_W'(len_i);
  assign hi_eff  = CNT_W'(hi_i);
endmodule

// File: rtl/fsync_frame_ctr.sv
module fsync_frame_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] len_next,
  output logic             load,
  output logic             wrap,
  output logic             running,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] len_q
);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] LEN_INIT = CNT_W'(fsync_pkg::MIN_FRAME);

  assign wrap = running && (cnt == len_q - ONE);
  assign load = !running || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      len_q   <= LEN_INIT;
    end else if (load) begin
      running <= 1'b1;
      cnt     <= '0;
      len_q   <= len_next;
    end else begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int HI_W  = 11,
  parameter int LO_W  = 3,
  parameter int LEN_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tdm_en,
  input  logic                  half_duty,
  input  logic [HI_W-LO_W-1:0]  hi_upper,
  input  logic [LO_W-1:0]       hi_lower,
  input  logic [LEN_W-1:0]      frame_len,
  output logic                  fsync,
  output logic                  frame_start
);
  localparam int CNT_W = (LEN_W > HI_W + 1) ? LEN_W : HI_W + 1;

  logic [CNT_W-1:0] len_eff, hi_eff;
  logic [CNT_W-1:0] cnt, len_q, hi_q;
  logic             load, wrap, running;

  fsync_cfg #(.HI_W(HI_W), .LO_W(LO_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_cfg (
    .tdm_en(tdm_en), .half_duty(half_duty), .hi_upper(hi_upper),
    .hi_lower(hi_lower), .frame_len(frame_len),
    .len_eff(len_eff), .hi_eff(hi_eff)
  );

  fsync_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .len_next(len_eff), .load(load), .wrap(wrap),
    .running(running), .cnt(cnt), .len_q(len_q)
  );

  // The high time is latched together with the frame length.
  always_ff @(posedge clk) begin
    if (rst)       hi_q <= '0;
    else if (load) hi_q <= hi_eff;
  end

  assign frame_start = running && (cnt == '0);
  assign fsync       = running && (cnt < hi_q);
endmodule

// File: rtl/fsync_gen_chk.sv
module fsync_gen_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             fsync,
  input logic             frame_start,
  input logic             load,
  input logic             wrap,
  input logic [CNT_W-1:0] hi_q,
  input logic [CNT_W-1:0] len_q
);
  // R2
  start_has_fsync_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> fsync);
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
  // R2
  rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync) |-> frame_start);
  // R5
  last_low_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> !fsync);
  // R7
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(hi_q));
  // R7
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(len_q));
endmodule

bind fsync_gen fsync_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fsync(fsync), .frame_start(frame_start),
  .load(load), .wrap(wrap), .hi_q(hi_q), .len_q(len_q)
);

// File: tb/fsync_gen_test.sv
module fsync_gen_test;
  typedef struct {
    bit    fs;
    bit    st;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tdm_en = 1'b0, half_duty = 1'b0;
  logic [7:0]  hi_upper = '0;
  logic [2:0]  hi_lower = '0;
  logic [11:0] frame_len = '0;
  logic        fsync, frame_start;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   started = 0, finished = 0;

  always #5 clk = ~clk;

  fsync_gen uut (
    .clk(clk), .rst(rst), .tdm_en(tdm_en), .half_duty(half_duty),
    .hi_upper(hi_upper), .hi_lower(hi_lower), .frame_len(frame_len),
    .fsync(fsync), .frame_start(frame_start)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic apply(input bit t, input bit h, input int up, input int lo, input int len);
    tdm_en = t; half_duty = h;
    hi_upper = 8'(up); hi_lower = 3'(lo); frame_len = 12'(len);
  endtask

  // Expected frame shape, written from the requirement text.
  task automatic push_frame(input bit t, input bit h, input int up, input int lo,
                            input int len, input string tag);
    int el, want;
    exp_t e;
    el = (len < 2) ? 2 : len;
    if (t && !h) want = up * 8 + lo + 1;
    else         want = el / 2;
    if (want >= el) want = el - 1;
    for (int i = 0; i < el; i++) begin
      e.fs = (i < want); e.st = (i == 0); e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  // The new settings go in while the previous frame is still running.
  task automatic step(input bit t, input bit h, input int up, input int lo,
                      input int len, input string tag);
    @(negedge clk);
    while (!frame_start) @(negedge clk);
    apply(t, h, up, lo, len);
    push_frame(t, h, up, lo, len, tag);
  endtask

  // Monitor: one expected item is popped and compared per cycle.
  initial begin
    wait (started);
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (fsync !== e.fs || frame_start !== e.st) begin
          n_bad++;
          $display("FAIL %s: fsync=%0b start=%0b expected fsync=%0b start=%0b",
                   e.tag, fsync, frame_start, e.fs, e.st);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    apply(1, 0, 0, 0, 8);
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (fsync !== 1'b0 || frame_start !== 1'b0) begin
        n_bad++;
        $display("FAIL R1: fsync=%0b start=%0b expected 0 0 in reset", fsync, frame_start);
      end
    end
    push_frame(1, 0, 0, 0, 8, "R1 R3 field 0");
    rst = 1'b0;
    started = 1;
    step(1, 0, 0, 1, 8,     "R3 field 1");
    step(1, 0, 1, 5, 20,    "R3 field 13");
    step(0, 0, 3, 0, 9,     "R4 non-TDM odd length");
    step(1, 1, 3, 0, 10,    "R4 half duty in TDM");
    step(1, 0, 2, 4, 10,    "R5 clamp");
    step(1, 0, 0, 0, 1,     "R6 length 1");
    step(0, 1, 0, 0, 0,     "R6 length 0");
    step(1, 0, 255, 7, 2100,"R8 field 2047");
    step(1, 0, 0, 2, 6,     "R7 R2 after long frame");
    step(0, 0, 0, 0, 3,     "R2 R4 length 3");
    while (exp_q.size() > 0) @(negedge clk);
    summary();
  end
endmodule